// File: doc/BRIEF.md
# External Reset Conditioner

This block turns a raw, asynchronous, active-low reset pin into a clean internal reset for a processor core. The pin is first brought into the core clock domain through a short flop chain. A run counter then rejects any low pulse that is too short to be a real reset. A pulse that passes the filter sets the core reset, which is then held for a fixed minimum number of clocks. If the pin is still low when that minimum has elapsed, the core reset stays asserted until the pin returns high.

When the core reset drops, the block raises a one-cycle load strobe and presents a fixed restart address for the program counter. A second qualified low pulse that arrives while the minimum hold is still counting restarts that count. A single continuous low episode is accepted only once, so a long press extends the reset rather than restarting it.

The `rst` input is a synchronous, active-high initialisation for the block's own flops. It is not the reset being conditioned.

Top module: `ext_reset_conditioner`

## Requirements
- R1: If `ext_rst_n` is sampled low at four or fewer consecutive rising edges, `core_rst` stays 0.
- R2: If `ext_rst_n` is sampled low at five or more consecutive rising edges, `core_rst` rises at the 7th rising edge, counting as the 1st the first edge that samples it low. This covers the two synchronizer edges and the five filter edges.
- R3: A reset that is accepted while the pin is already high again holds `core_rst` at 1 for exactly 18 clock cycles.
- R4: While the pin stays low, `core_rst` stays 1. When the 18-cycle minimum has already elapsed, `core_rst` falls at the 2nd rising edge after the first edge that samples the pin high. Otherwise the 18-cycle minimum decides the release.
- R5: A new qualified low pulse accepted during the hold restarts the count. `core_rst` then falls 18 edges after the new acceptance edge.
- R6: `pc_load` is 1 for exactly one cycle, the first cycle in which `core_rst` is 0 after a release. `start_pc` always reads 16'h000C.
- R7: A high sample on the pin clears the filter run. Four low samples, then one high sample, then four low samples give no reset.
- R8: While `rst` is asserted and after it is released, `core_rst` and `pc_load` are 0 until a qualified pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high initialisation of the block's flops |
| ext_rst_n | input | 1 | Raw asynchronous reset pin, active low |
| core_rst | output | 1 | Conditioned internal reset, active high |
| pc_load | output | 1 | One-cycle strobe in the first cycle after release |
| start_pc | output | 16 | Restart address for the program counter |

## Verification
The hardest case to reach from the ports is a second qualified pulse landing inside an ongoing hold. The filter must have seen the pin high long enough to clear, and the new run must finish before the first 18-cycle count expires. The stimulus releases the pin for exactly two samples after a five-sample pulse and then drives another five-sample pulse. The expected release is then placed against the second acceptance edge. The single-sample gap in the R7 case, and pulses of exactly four and five samples, pin down the filter boundary.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int unsigned DEF_FILT_LEN   = 4;
    localparam int unsigned DEF_HOLD_LEN   = 18;
    localparam int unsigned DEF_SYNC_DEPTH = 2;
    localparam int unsigned DEF_PC_W       = 16;
    localparam logic [15:0] DEF_START_PC   = 16'h000C;

    // Stretcher phases: running, minimum hold counting, extended by pin
    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_HOLD   = 2'd1,
        PH_EXTEND = 2'd2
    } stretch_ph_t;

    // Width needed to hold values 0..max_v
    function automatic int unsigned cnt_width(input int unsigned max_v);
        return (max_v < 2) ? 1 : $clog2(max_v + 1);
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic line_low
);
    logic [DEPTH-1:0] chain_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign line_low = ~chain_q[DEPTH-1];

endmodule

// File: rtl/rstc_filter.sv
module rstc_filter
    import rstc_pkg::*;
#(
    parameter int unsigned FILT_LEN = DEF_FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic line_low,
    output logic accept
);
    localparam int unsigned RUN_MAX = FILT_LEN + 1;
    localparam int unsigned RUN_W   = cnt_width(RUN_MAX);

    logic [RUN_W-1:0] run_q;

    // Counts consecutive low samples; saturates past the accept point so
    // that one low episode produces one acceptance only.
    always_ff @(posedge clk) begin
        if (rst || !line_low) begin
            run_q <= '0;
        end else if (run_q != RUN_W'(RUN_MAX)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign accept = line_low && (run_q == RUN_W'(FILT_LEN));

    // R1
    accept_prev_low_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(line_low));

    // R7
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !line_low |=> (run_q == '0));

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch
    import rstc_pkg::*;
#(
    parameter int unsigned HOLD_LEN = DEF_HOLD_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic line_low,
    output logic core_rst,
    output logic pc_load
);
    localparam int unsigned HOLD_W = cnt_width(HOLD_LEN);

    stretch_ph_t       ph_q;
    logic [HOLD_W-1:0] hold_q;
    logic              load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_RUN;
            hold_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (accept) begin
                ph_q   <= PH_HOLD;
                hold_q <= HOLD_W'(1);
            end else begin
                unique case (ph_q)
                    PH_HOLD: begin
                        if (hold_q == HOLD_W'(HOLD_LEN)) begin
                            if (line_low) begin
                                ph_q <= PH_EXTEND;
                            end else begin
                                ph_q   <= PH_RUN;
                                load_q <= 1'b1;
                            end
                        end else begin
                            hold_q <= hold_q + 1'b1;
                        end
                    end
                    PH_EXTEND: begin
                        if (!line_low) begin
                            ph_q   <= PH_RUN;
                            load_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign core_rst = (ph_q != PH_RUN);
    assign pc_load  = load_q;

    // Independent cycle tally since the last acceptance
    logic [HOLD_W-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)                                         seen_q <= '0;
        else if (accept)                                 seen_q <= HOLD_W'(1);
        else if (core_rst && seen_q != HOLD_W'(HOLD_LEN)) seen_q <= seen_q + 1'b1;
    end

    // R3
    hold_min_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rst && seen_q != HOLD_W'(HOLD_LEN)) |=> core_rst);

    // R4
    pin_extend_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rst && line_low) |=> core_rst);

    // R2
    rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> $past(accept));

    // R6
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (!core_rst && $past(core_rst)));

    // R6
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

endmodule

// File: rtl/ext_reset_conditioner.sv
module ext_reset_conditioner
    import rstc_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH,
    parameter int unsigned FILT_LEN   = DEF_FILT_LEN,
    parameter int unsigned HOLD_LEN   = DEF_HOLD_LEN,
    parameter int unsigned PC_W       = DEF_PC_W,
    parameter logic [PC_W-1:0] START_PC = PC_W'(DEF_START_PC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_rst_n,
    output logic            core_rst,
    output logic            pc_load,
    output logic [PC_W-1:0] start_pc
);
    logic line_low;
    logic accept;

    rstc_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_n  (ext_rst_n),
        .line_low (line_low)
    );

    rstc_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .line_low (line_low),
        .accept   (accept)
    );

    rstc_stretch #(.HOLD_LEN(HOLD_LEN)) u_stretch (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .line_low (line_low),
        .core_rst (core_rst),
        .pc_load  (pc_load)
    );

    assign start_pc = START_PC;

    // R8
    init_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!core_rst && !pc_load));

endmodule

// File: tb/ext_reset_conditioner_bench.sv
`timescale 1ns/1ps
module ext_reset_conditioner_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_rst_n;
    logic        core_rst;
    logic        pc_load;
    logic [15:0] start_pc;

    always #2 clk = ~clk;

    ext_reset_conditioner u_ext_reset_conditioner (
        .clk       (clk),
        .rst       (rst),
        .ext_rst_n (ext_rst_n),
        .core_rst  (core_rst),
        .pc_load   (pc_load),
        .start_pc  (start_pc)
    );

    int cyc   = 0;
    int total = 0;
    int bad   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  er;
        logic  pl;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;

    task automatic push(input int at, input logic er, input logic pl, input string tag);
        exp_t e;
        e.at = at; e.er = er; e.pl = pl; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares outputs at the cycle each expectation names
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            mon_e = q.pop_front();
            total++;
            if (mon_e.at != cyc || core_rst !== mon_e.er || pc_load !== mon_e.pl) begin
                bad++;
                $display("FAIL %s cyc=%0d: core_rst=%b pc_load=%b expected core_rst=%b pc_load=%b",
                         mon_e.tag, cyc, core_rst, pc_load, mon_e.er, mon_e.pl);
            end
        end
    end

    task automatic low_for(input int n);
        ext_rst_n = 1'b0;
        repeat (n) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    int n0;

    initial begin
        rst = 1'b1;
        ext_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8: outputs quiet during rst
        total++;
        if (core_rst !== 1'b0 || pc_load !== 1'b0) begin
            bad++;
            $display("FAIL R8 in rst: core_rst=%b pc_load=%b expected 0 0", core_rst, pc_load);
        end
        rst = 1'b0;
        push(cyc + 1, 1'b0, 1'b0, "R8");
        push(cyc + 4, 1'b0, 1'b0, "R8");
        // R6: restart address
        total++;
        if (start_pc !== 16'h000C) begin
            bad++;
            $display("FAIL R6 start_pc=%h expected 000c", start_pc);
        end
        repeat (8) @(negedge clk);

        // R2/R3/R6: five-sample pulse, minimum hold
        n0 = cyc;
        push(n0 + 6,  1'b0, 1'b0, "R2");
        push(n0 + 7,  1'b1, 1'b0, "R2");
        push(n0 + 24, 1'b1, 1'b0, "R3");
        push(n0 + 25, 1'b0, 1'b1, "R3_R6");
        push(n0 + 26, 1'b0, 1'b0, "R6");
        low_for(5);
        repeat (40) @(negedge clk);

        // R1: four-sample pulse is rejected
        n0 = cyc;
        for (int k = 5; k <= 12; k++) push(n0 + k, 1'b0, 1'b0, "R1");
        low_for(4);
        repeat (30) @(negedge clk);

        // R7: gap of one high sample clears the run
        n0 = cyc;
        for (int k = 6; k <= 16; k++) push(n0 + k, 1'b0, 1'b0, "R7");
        ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_rst_n = 1'b1;
        @(negedge clk);
        low_for(4);
        repeat (30) @(negedge clk);

        // R4: long press extends past the minimum
        n0 = cyc;
        push(n0 + 7,  1'b1, 1'b0, "R4");
        push(n0 + 30, 1'b1, 1'b0, "R4");
        push(n0 + 42, 1'b1, 1'b0, "R4");
        push(n0 + 43, 1'b0, 1'b1, "R4_R6");
        push(n0 + 44, 1'b0, 1'b0, "R6");
        low_for(40);
        repeat (40) @(negedge clk);

        // R4: medium press, minimum hold dominates
        n0 = cyc;
        push(n0 + 24, 1'b1, 1'b0, "R4");
        push(n0 + 25, 1'b0, 1'b1, "R4");
        low_for(10);
        repeat (40) @(negedge clk);

        // R5: second qualified pulse during hold restarts count
        n0 = cyc;
        push(n0 + 7,  1'b1, 1'b0, "R5");
        push(n0 + 25, 1'b1, 1'b0, "R5");
        push(n0 + 31, 1'b1, 1'b0, "R5");
        push(n0 + 32, 1'b0, 1'b1, "R5");
        low_for(5);
        repeat (2) @(negedge clk);
        low_for(5);
        repeat (40) @(negedge clk);

        while (q.size() > 0) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired at cyc=%0d expected completion", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule